// File: doc/BRIEF.md
# Multi-Level Interrupt Priority Arbiter

This block sits between a set of peripheral modules and a processor core and decides which interrupt request the core services next. Each source drives a 3-bit request level (0 means no request, 1 to 7 are priorities) and has a fixed 4-bit arbitration number. Requests are compared against the current exception mask. Only a request above the mask, or any level-7 request, is eligible.

When an eligible request appears, the arbiter opens a window of a fixed number of clock cycles. It samples all requests during that window, so a later request can still overtake an earlier one. At the end of the window, which stands for the vector fetch, it freezes the winner. It reports the winner's level and source in a one-cycle take pulse, pushes the old mask onto a small stack and raises the mask to the winner's level. A return strobe from the core pops the stack and restores the mask.

A winner whose arbitration number is zero is reported as spurious. A source that has been taken stays out of arbitration until it drops its request line.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset, `irq_pend`, `take_vld`, `spurious`, `cur_mask`, `stk_ovf` and `stk_unf` are all 0.
- R2: Among eligible requests the highest level wins. A level field of 0 means no request.
- R3: Among eligible requests of the same level, the source with the larger arbitration number wins. If two sources have the same level and the same number, the lower source index wins.
- R4: A request whose level is less than or equal to `cur_mask` is not taken until the mask falls below its level.
- R5: A level-7 request is taken even when `cur_mask` is 7, so level 7 can interrupt level 7.
- R6: `take_vld` is a one-cycle pulse with `win_lvl` and `win_src`. With a lone request driven before clock edge E0, it is seen after edge E0+WIN_CYC. From that same edge, `cur_mask` equals `win_lvl`.
- R7: A `rte` strobe restores `cur_mask` to the value saved at the matching take. An eligible request held back by the mask is then taken at once. If `rte` is high on the cycle that would end a window, the take waits one cycle.
- R8: Any request present before the edge that ends the window takes part in arbitration. A request raised after that edge has no effect on that take.
- R9: If the winning source's arbitration number is 0, `spurious` is 1 together with `take_vld`. Otherwise `spurious` is 0.
- R10: A source that has been taken is not taken again until its level field returns to 0.
- R11: A take with STK_DEPTH entries already saved sets the sticky flag `stk_ovf`. A `rte` with nothing saved sets the sticky flag `stk_unf` and leaves `cur_mask` unchanged.
- R12: `irq_pend` is 1 from the cycle after an eligible request exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_lvl | input | N_SRC*3 | Request level per source, source i at bits [3i+2:3i] |
| arb_num | input | N_SRC*ARB_W | Arbitration number per source, source i at bits [ARB_W*i+ARB_W-1:ARB_W*i] |
| rte | input | 1 | Return-from-exception strobe |
| irq_pend | output | 1 | An eligible request exists |
| take_vld | output | 1 | One-cycle acceptance pulse |
| win_lvl | output | 3 | Level of the accepted request |
| win_src | output | $clog2(N_SRC) | Index of the accepted source |
| spurious | output | 1 | Accepted source had arbitration number 0 |
| cur_mask | output | 3 | Current exception mask |
| stk_ovf | output | 1 | Sticky saved-mask overflow |
| stk_unf | output | 1 | Sticky saved-mask underflow |

## Verification
On every cycle, the assertions check the following:
- A take is a single pulse.
- The mask equals the accepted level right after a take.
- Every accepted level was above the previous mask or was 7.
- `spurious` never appears without a take.
- The saved-mask stack is never pushed and popped together, and it stays within its depth.

Some behaviour only the bench scenarios can show:
- The tie-break by arbitration number.
- A late request winning inside the window, or being ignored after it.
- The order in which held requests are taken after each return.
- A level-7 request re-entering level 7.
- The sticky error flags.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W   = 3;
  localparam int MAX_LVL = 7;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_win_sel.sv
module irq_win_sel
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int ARB_W = 4,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC*LVL_W-1:0] req_lvl,
  input  logic [N_SRC*ARB_W-1:0] arb_num,
  input  logic [N_SRC-1:0]       elig,
  output logic                   any,
  output lvl_t                   best_lvl,
  output logic [ARB_W-1:0]       best_arb,
  output logic [SRC_W-1:0]       best_src
);
  // Level first, then arbitration number; strict compare keeps lower index on ties.
  always_comb begin
    any      = 1'b0;
    best_lvl = '0;
    best_arb = '0;
    best_src = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!any ||
          req_lvl[i*LVL_W +: LVL_W] > best_lvl ||
          (req_lvl[i*LVL_W +: LVL_W] == best_lvl && arb_num[i*ARB_W +: ARB_W] > best_arb))) begin
        any      = 1'b1;
        best_lvl = req_lvl[i*LVL_W +: LVL_W];
        best_arb = arb_num[i*ARB_W +: ARB_W];
        best_src = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_mask_stack.sv
module irq_mask_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  lvl_t push_val,
  output lvl_t top_val,
  output logic empty,
  output logic ovf,
  output logic unf
);
  lvl_t            mem [DEPTH];
  logic [SP_W-1:0] sp;

  assign empty   = (sp == '0);
  assign top_val = empty ? '0 : mem[sp - 1'b1];

  always_ff @(posedge clk) begin
    if (push && sp < SP_W'(DEPTH)) mem[sp] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else if (push) begin
      if (sp < SP_W'(DEPTH)) sp <= sp + 1'b1;
      else                   ovf <= 1'b1;
    end else if (pop) begin
      if (!empty) sp  <= sp - 1'b1;
      else        unf <= 1'b1;
    end
  end

  AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (rst) !(push && pop)); // R7
  AST_SP_BOUND:    assert property (@(posedge clk) disable iff (rst) sp <= SP_W'(DEPTH)); // R11
  AST_UNF_STICKY:  assert property (@(posedge clk) disable iff (rst) unf |=> unf); // R11
  AST_OVF_STICKY:  assert property (@(posedge clk) disable iff (rst) ovf |=> ovf); // R11
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int N_SRC     = 4,
  parameter int ARB_W     = 4,
  parameter int WIN_CYC   = 4,
  parameter int STK_DEPTH = 8,
  localparam int SRC_W = $clog2(N_SRC),
  localparam int CNT_W = $clog2(WIN_CYC + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC*3-1:0]     req_lvl,
  input  logic [N_SRC*ARB_W-1:0] arb_num,
  input  logic                   rte,
  output logic                   irq_pend,
  output logic                   take_vld,
  output logic [2:0]             win_lvl,
  output logic [SRC_W-1:0]       win_src,
  output logic                   spurious,
  output logic [2:0]             cur_mask,
  output logic                   stk_ovf,
  output logic                   stk_unf
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

  logic [N_SRC-1:0] insvc, elig;
  logic             any;
  lvl_t             sel_lvl, stk_top;
  logic [ARB_W-1:0] sel_arb;
  logic [SRC_W-1:0] sel_src;
  logic             in_win, stk_empty, push;
  logic [CNT_W-1:0] cnt;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    logic [LVL_W-1:0] l;
    assign l       = req_lvl[g*LVL_W +: LVL_W];
    assign elig[g] = (l != '0) && !insvc[g] &&
                     ((l > cur_mask) || (l == lvl_t'(MAX_LVL)));
  end

  irq_win_sel #(.N_SRC(N_SRC), .ARB_W(ARB_W)) u_sel (
    .req_lvl(req_lvl), .arb_num(arb_num), .elig(elig),
    .any(any), .best_lvl(sel_lvl), .best_arb(sel_arb), .best_src(sel_src)
  );

  assign push = in_win && (cnt == LAST) && !rte && any;

  irq_mask_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(push), .pop(rte), .push_val(cur_mask),
    .top_val(stk_top), .empty(stk_empty), .ovf(stk_ovf), .unf(stk_unf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      insvc    <= '0;
      in_win   <= 1'b0;
      cnt      <= '0;
      take_vld <= 1'b0;
      win_lvl  <= '0;
      win_src  <= '0;
      spurious <= 1'b0;
      cur_mask <= '0;
      irq_pend <= 1'b0;
    end else begin
      take_vld <= 1'b0;
      spurious <= 1'b0;
      irq_pend <= any;
      for (int i = 0; i < N_SRC; i++)
        if (req_lvl[i*LVL_W +: LVL_W] == '0) insvc[i] <= 1'b0;
      if (rte && !stk_empty) cur_mask <= stk_top;
      if (!in_win) begin
        if (any && !rte) begin
          in_win <= 1'b1;
          cnt    <= '0;
        end
      end else if (cnt == LAST) begin
        if (!rte) begin
          in_win <= 1'b0;
          if (any) begin
            take_vld       <= 1'b1;
            win_lvl        <= sel_lvl;
            win_src        <= sel_src;
            spurious       <= (sel_arb == '0);
            cur_mask       <= sel_lvl;
            insvc[sel_src] <= 1'b1;
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_TAKE_PULSE:  assert property (@(posedge clk) disable iff (rst) take_vld |=> !take_vld); // R6
  AST_MASK_RAISED: assert property (@(posedge clk) disable iff (rst) take_vld |-> cur_mask == win_lvl); // R6
  AST_ABOVE_MASK:  assert property (@(posedge clk) disable iff (rst)
                     take_vld |-> (win_lvl > $past(cur_mask) || win_lvl == 3'd7)); // R4
  AST_LVL_VALID:   assert property (@(posedge clk) disable iff (rst) take_vld |-> win_lvl != 3'd0); // R2
  AST_SPUR_TAKE:   assert property (@(posedge clk) disable iff (rst) spurious |-> take_vld); // R9
endmodule

// File: tb/sim_irq_prio_arb.sv
`timescale 1ns/1ps
module sim_irq_prio_arb;
  localparam int N = 4, AW = 4, WIN = 4, DEP = 8, SET = WIN + 3;

  typedef struct packed { logic spur; logic [1:0] src; logic [2:0] lvl; } exp_t;

  logic clk = 0, rst = 1, rte = 0;
  logic [2:0] lv [N];
  logic [N*3-1:0] req_lvl;
  logic [N*AW-1:0] arb_num;
  logic irq_pend, take_vld, spurious, stk_ovf, stk_unf;
  logic [2:0] win_lvl, cur_mask;
  logic [1:0] win_src;
  exp_t q [$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // Arbitration numbers: src0=7, src1=9, src2=1, src3=0 (spurious).
  assign arb_num = {4'd0, 4'd1, 4'd9, 4'd7};
  always_comb for (int i = 0; i < N; i++) req_lvl[i*3 +: 3] = lv[i];

  irq_prio_arb #(.N_SRC(N), .ARB_W(AW), .WIN_CYC(WIN), .STK_DEPTH(DEP)) u0 (
    .clk(clk), .rst(rst), .req_lvl(req_lvl), .arb_num(arb_num), .rte(rte),
    .irq_pend(irq_pend), .take_vld(take_vld), .win_lvl(win_lvl), .win_src(win_src),
    .spurious(spurious), .cur_mask(cur_mask), .stk_ovf(stk_ovf), .stk_unf(stk_unf));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_take(input int lvl, input int src, input bit sp);
    exp_t e;
    e.lvl = 3'(lvl); e.src = 2'(src); e.spur = sp;
    q.push_back(e);
  endtask

  task automatic do_rte();
    rte = 1; step(1); rte = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    for (int i = 0; i < N; i++) lv[i] = 0;
    step(3); rst = 0; step(1);
  endtask

  // Monitor: every take must match the next queued expectation.
  always @(negedge clk) begin
    if (!rst && take_vld) begin
      if (q.size() == 0) chk(0, "R4/R8 unexpected take", int'(win_src), -1);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(win_lvl == e.lvl, "R2 take level", int'(win_lvl), int'(e.lvl));
        chk(win_src == e.src, "R3 take source", int'(win_src), int'(e.src));
        chk(spurious == e.spur, "R9 spurious flag", int'(spurious), int'(e.spur));
      end
    end
  end

  initial begin
    do_reset();
    chk({irq_pend, take_vld, spurious, cur_mask, stk_ovf, stk_unf} == 0, "R1 reset state",
        int'({irq_pend, take_vld, spurious, cur_mask, stk_ovf, stk_unf}), 0);

    // R6 exact timing, R12 pending
    lv[0] = 4; expect_take(4, 0, 0);
    step(1);
    chk(irq_pend == 1, "R12 irq_pend", int'(irq_pend), 1);
    step(WIN - 1);
    chk(take_vld == 0, "R6 take before window end", int'(take_vld), 0);
    step(1);
    chk(take_vld == 1, "R6 take at window end", int'(take_vld), 1);
    chk(cur_mask == 4, "R6 mask raised", int'(cur_mask), 4);
    // R4: same level after fetch is held; R8 it had no effect on that take
    step(1); lv[1] = 4; step(SET);
    chk(cur_mask == 4, "R4 held at mask", int'(cur_mask), 4);
    chk(irq_pend == 0, "R12 no pending when masked", int'(irq_pend), 0);
    // R7: return releases held same-level request
    lv[0] = 0; expect_take(4, 1, 0); do_rte(); step(SET);
    chk(cur_mask == 4, "R7 held taken after return", int'(cur_mask), 4);
    lv[1] = 0; do_rte(); step(2);
    chk(cur_mask == 0, "R7 mask restored", int'(cur_mask), 0);

    // R8 / R3: later same-level request inside window wins
    lv[0] = 4; step(2); lv[1] = 4;
    expect_take(4, 1, 0); expect_take(4, 0, 0);
    step(SET);
    lv[1] = 0; do_rte(); step(SET);
    lv[0] = 0; do_rte(); step(2);
    chk(cur_mask == 0, "R8 mask back to 0", int'(cur_mask), 0);

    // R7 nesting with held higher request taken before resume
    lv[0] = 3; expect_take(3, 0, 0); step(SET);
    lv[2] = 5; expect_take(5, 2, 0); step(SET);
    chk(cur_mask == 5, "R6 preempt mask", int'(cur_mask), 5);
    lv[1] = 5; step(SET);
    lv[2] = 0; expect_take(5, 1, 0); do_rte();
    chk(cur_mask == 3, "R7 restore to 3", int'(cur_mask), 3);
    step(SET);
    chk(cur_mask == 5, "R7 held level 5 taken", int'(cur_mask), 5);
    lv[1] = 0; do_rte(); step(1);
    chk(cur_mask == 3, "R7 back to 3", int'(cur_mask), 3);
    lv[0] = 0; do_rte(); step(2);

    // R5 level 7 re-enters level 7; R10 in-service source not retaken
    lv[0] = 7; expect_take(7, 0, 0); step(SET);
    lv[1] = 7; expect_take(7, 1, 0); step(SET);
    chk(cur_mask == 7, "R5 mask 7", int'(cur_mask), 7);
    step(SET); // R10: both lines still high, no further takes
    lv[0] = 0; lv[1] = 0; do_rte(); do_rte(); step(2);
    chk(cur_mask == 0, "R5 mask back to 0", int'(cur_mask), 0);

    // R9 spurious source
    lv[3] = 2; expect_take(2, 3, 1); step(SET);
    lv[3] = 0; do_rte(); step(2);

    // R2 highest level among simultaneous
    lv[0] = 2; lv[1] = 6; lv[2] = 3;
    expect_take(6, 1, 0); expect_take(3, 2, 0); expect_take(2, 0, 0);
    step(SET);
    lv[1] = 0; do_rte(); step(SET);
    lv[2] = 0; do_rte(); step(SET);
    chk(cur_mask == 2, "R2 last level", int'(cur_mask), 2);
    lv[0] = 0; do_rte(); step(2);
    chk(stk_unf == 0, "R11 no underflow yet", int'(stk_unf), 0);

    // R11 underflow
    do_rte(); step(1);
    chk(stk_unf == 1, "R11 underflow flag", int'(stk_unf), 1);
    chk(cur_mask == 0, "R11 mask unchanged on underflow", int'(cur_mask), 0);

    // R11 overflow via repeated level-7 takes
    do_reset();
    for (int k = 0; k < DEP + 1; k++) begin
      lv[0] = 7; expect_take(7, 0, 0); step(SET);
      chk(stk_ovf == (k == DEP), "R11 overflow flag", int'(stk_ovf), int'(k == DEP));
      lv[0] = 0; step(2);
    end

    step(4);
    chk(q.size() == 0, "R8 all expected takes seen", q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule